// File: doc/BRIEF.md
# Power-State Peripheral Clock Gate

This block delivers the two clocks of one peripheral, its kernel clock and its bus-interface clock, and stops them when the peripheral is not permitted to run. The decision is taken from three software enable bits (run, sleep and autonomous), the power state of the CPU, the state of the always-on domain the peripheral sits in, and a flag that says whether that domain is powered. One instance is placed per peripheral. Peripherals that share a kernel clock source still get a gate each, because every peripheral has its own enables.

The decision crosses into each clock domain through a short flop synchroniser. A latch that is transparent while its source clock is low then holds the enable, and the latch output is ANDed with the clock. The gated outputs therefore never carry a shortened pulse. An active flag, synchronised to the bus clock, tells the bus side whether the kernel clock gate is currently open.

Top module: `pcg_top`

## Requirements
- R1: With the CPU state code 2'b00 (running) and the domain powered, both gated clocks run whenever the run enable is 1 and are stopped when it is 0. The sleep and autonomous enables have no effect in this state.
- R2: With the CPU state code 2'b01 (sleeping) and the domain powered, the clocks run only when the run enable and the sleep enable are both 1.
- R3: With the CPU state code 2'b10 (stopped) and the domain powered, the clocks run only when the run enable and the autonomous enable are both 1 and the domain state input is 1 (domain running). A domain state of 0 stops them.
- R4: While the domain-powered input is 0, both gated clocks stay low whatever the enables and the CPU state.
- R5: The kernel clock gate and the bus clock gate follow the same decision, each in its own clock domain.
- R6: When the decision changes from off to on between two rising edges of a source clock, the first two rising edges after the change are suppressed on that gated clock and the third is passed.
- R7: When the decision changes from on to off between two rising edges of a source clock, the first two rising edges after the change are still passed on that gated clock and the third is suppressed.
- R8: While the active-low reset is 0, both gated clocks and the active flag are low, even with every enable set.
- R9: Once settled, the active flag is 1 exactly when the kernel clock gate is open and 0 when it is closed. It changes only on the bus clock.
- R10: The CPU state code 2'b11 is reserved. In that state both gated clocks are stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ker_clk_i | input | 1 | Kernel source clock |
| bus_clk_i | input | 1 | Bus-interface source clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released per domain |
| run_en_i | input | 1 | Run-mode enable |
| slp_en_i | input | 1 | Sleep-mode enable |
| auto_en_i | input | 1 | Autonomous-mode enable |
| cpu_state_i | input | 2 | CPU power state: 00 run, 01 sleep, 10 stop, 11 reserved |
| dom_run_i | input | 1 | Always-on domain state, 1 = running |
| dom_pwr_i | input | 1 | Peripheral domain is powered |
| ker_gck_o | output | 1 | Gated kernel clock |
| bus_gck_o | output | 1 | Gated bus-interface clock |
| active_o | output | 1 | Kernel gate open, in the bus clock domain |

## Verification
The hardest thing to observe from the ports is the exact edge at which a gate opens or closes. Only the pulses on the gated clock show it, so the enable has to be changed at a known phase of the source clock. The stimulus waits for a rising kernel edge, changes the inputs a short delay later, and then counts gated pulses edge by edge over the next three source edges. The stopped-CPU cases are also reached by walking the CPU state, the autonomous bit and the domain state through their combinations while the domain stays powered, and then removing power with every enable still set.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  typedef enum logic [1:0] {
    CPU_RUN   = 2'b00,
    CPU_SLEEP = 2'b01,
    CPU_STOP  = 2'b10,
    CPU_RSVD  = 2'b11
  } cpu_state_e;

  localparam int unsigned GATE_KER = 0;
  localparam int unsigned GATE_BUS = 1;
  localparam int unsigned N_GATES  = 2;

endpackage

// File: rtl/pcg_sync.sv
module pcg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES > 1) begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d_i};
    end else begin : g_single
      always_comb stg_d = d_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pcg_policy.sv
module pcg_policy
  import pcg_pkg::*;
(
  input  logic       run_en_i,
  input  logic       slp_en_i,
  input  logic       auto_en_i,
  input  logic [1:0] cpu_state_i,
  input  logic       dom_run_i,
  input  logic       dom_pwr_i,
  output logic       want_o
);

  cpu_state_e state;
  logic       mode_ok;

  always_comb begin
    state = cpu_state_e'(cpu_state_i);
    unique case (state)
      CPU_RUN:   mode_ok = 1'b1;
      CPU_SLEEP: mode_ok = slp_en_i;
      CPU_STOP:  mode_ok = auto_en_i & dom_run_i;
      default:   mode_ok = 1'b0;
    endcase
    want_o = dom_pwr_i & run_en_i & mode_ok;
  end

endmodule

// File: rtl/pcg_gate.sv
module pcg_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_req_i,
  output logic gck_o,
  output logic open_o,
  output logic settled_o,
  output logic rst_n_o
);

  localparam int unsigned AGE_W = $clog2(SYNC_STAGES + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(SYNC_STAGES);

  logic             rst_sync_n;
  logic             en_s;
  logic             open_q;
  logic [AGE_W-1:0] age_q;
  logic [AGE_W-1:0] age_d;

  pcg_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (1'b1),
    .q_o    (rst_sync_n)
  );

  pcg_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .d_i    (en_req_i),
    .q_o    (en_s)
  );

  // Transparent while the source clock is low, so the enable never
  // changes during a high phase of the gated output.
  always_latch begin
    if (!clk_i) open_q <= en_s;
  end

  assign gck_o = clk_i & open_q;

  // Counts edges since reset release, up to the synchroniser depth.
  always_comb begin
    if (age_q == AGE_MAX) age_d = age_q;
    else                  age_d = age_q + AGE_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) age_q <= '0;
    else             age_q <= age_d;
  end

  assign open_o    = open_q;
  assign settled_o = (age_q == AGE_MAX);
  assign rst_n_o   = rst_sync_n;

  always_ff @(posedge clk_i) begin
    if (!rst_sync_n) begin
      AST_QUIET_IN_RESET: assert (!open_q) else $error("gate open during reset"); // R8
    end
  end

  AST_OPEN_ON_TIME: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (settled_o && $past(en_req_i, SYNC_STAGES)) |-> open_q) else $error("gate late to open"); // R6

  AST_SHUT_ON_TIME: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (settled_o && !$past(en_req_i, SYNC_STAGES)) |-> !open_q) else $error("gate late to close"); // R7

endmodule

// File: rtl/pcg_top.sv
module pcg_top
  import pcg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       ker_clk_i,
  input  logic       bus_clk_i,
  input  logic       rst_ni,
  input  logic       run_en_i,
  input  logic       slp_en_i,
  input  logic       auto_en_i,
  input  logic [1:0] cpu_state_i,
  input  logic       dom_run_i,
  input  logic       dom_pwr_i,
  output logic       ker_gck_o,
  output logic       bus_gck_o,
  output logic       active_o
);

  logic               want;
  logic [N_GATES-1:0] src_clk;
  logic [N_GATES-1:0] gck;
  logic [N_GATES-1:0] gate_open;
  logic [N_GATES-1:0] gate_settled;
  logic [N_GATES-1:0] gate_rst_n;

  pcg_policy u_policy (
    .run_en_i    (run_en_i),
    .slp_en_i    (slp_en_i),
    .auto_en_i   (auto_en_i),
    .cpu_state_i (cpu_state_i),
    .dom_run_i   (dom_run_i),
    .dom_pwr_i   (dom_pwr_i),
    .want_o      (want)
  );

  assign src_clk[GATE_KER] = ker_clk_i;
  assign src_clk[GATE_BUS] = bus_clk_i;

  generate
    for (genvar g = 0; g < N_GATES; g++) begin : g_gate
      pcg_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk_i     (src_clk[g]),
        .rst_ni    (rst_ni),
        .en_req_i  (want),
        .gck_o     (gck[g]),
        .open_o    (gate_open[g]),
        .settled_o (gate_settled[g]),
        .rst_n_o   (gate_rst_n[g])
      );
    end
  endgenerate

  pcg_sync #(.STAGES(SYNC_STAGES)) u_active_sync (
    .clk_i  (bus_clk_i),
    .rst_ni (gate_rst_n[GATE_BUS]),
    .d_i    (gate_open[GATE_KER]),
    .q_o    (active_o)
  );

  assign ker_gck_o = gck[GATE_KER];
  assign bus_gck_o = gck[GATE_BUS];

  AST_UNPOWERED_SHUT: assert property (@(posedge ker_clk_i) disable iff (!gate_rst_n[GATE_KER])
    (gate_settled[GATE_KER] && !$past(dom_pwr_i, SYNC_STAGES)) |-> !gate_open[GATE_KER])
    else $error("kernel clock with domain unpowered"); // R4

  AST_STOP_NEEDS_AUTO: assert property (@(posedge ker_clk_i) disable iff (!gate_rst_n[GATE_KER])
    (gate_settled[GATE_KER] && ($past(cpu_state_i, SYNC_STAGES) == CPU_STOP)
     && !$past(auto_en_i, SYNC_STAGES)) |-> !gate_open[GATE_KER])
    else $error("kernel clock in stop without autonomous enable"); // R3

endmodule

// File: tb/pcg_top_test.sv
module pcg_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int BUS_PERIOD = 16;
  localparam int KER_WIN    = 8;
  localparam int BUS_WIN    = 5;

  logic       ker_clk = 1'b0;
  logic       bus_clk = 1'b0;
  logic       rst_n;
  logic       run_en, slp_en, auto_en, dom_run, dom_pwr;
  logic [1:0] cpu_state;
  logic       ker_gck, bus_gck, active;

  int checks = 0;
  int errors = 0;
  int kcnt   = 0;
  int bcnt   = 0;
  bit mon_busy = 1'b0;
  bit done     = 1'b0;

  typedef struct {
    bit    on;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  always #(CLK_PERIOD/2) ker_clk = ~ker_clk;
  always #(BUS_PERIOD/2) bus_clk = ~bus_clk;

  always @(posedge ker_gck) kcnt++;
  always @(posedge bus_gck) bcnt++;

  pcg_top uut (
    .ker_clk_i   (ker_clk),
    .bus_clk_i   (bus_clk),
    .rst_ni      (rst_n),
    .run_en_i    (run_en),
    .slp_en_i    (slp_en),
    .auto_en_i   (auto_en),
    .cpu_state_i (cpu_state),
    .dom_run_i   (dom_run),
    .dom_pwr_i   (dom_pwr),
    .ker_gck_o   (ker_gck),
    .bus_gck_o   (bus_gck),
    .active_o    (active)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected decision from R1-style rules written independently.
  function automatic bit model(input bit r, input bit s, input bit a,
                               input logic [1:0] c, input bit dr, input bit p);
    bit m;
    if (!p || !r)          m = 1'b0;
    else if (c == 2'b00)   m = 1'b1;
    else if (c == 2'b01)   m = s;
    else if (c == 2'b10)   m = a && dr;
    else                   m = 1'b0;
    return m;
  endfunction

  task automatic drive(input bit r, input bit s, input bit a, input logic [1:0] c,
                       input bit dr, input bit p, input string tag);
    exp_t e;
    run_en = r; slp_en = s; auto_en = a; cpu_state = c; dom_run = dr; dom_pwr = p;
    repeat (8) @(posedge bus_clk);
    e.on  = model(r, s, a, c, dr, p);
    e.tag = tag;
    exp_q.push_back(e);
    wait (exp_q.size() == 0 && !mon_busy);
  endtask

  // Monitor: pops expectations and measures the outputs.
  initial begin
    forever begin
      exp_t e;
      int k0, b0;
      wait (exp_q.size() > 0);
      mon_busy = 1'b1;
      e = exp_q.pop_front();
      k0 = kcnt;
      b0 = bcnt;
      repeat (KER_WIN) @(posedge ker_clk);
      #1;
      check((kcnt - k0) == (e.on ? KER_WIN : 0), e.tag, "kernel pulses",
            kcnt - k0, e.on ? KER_WIN : 0);
      repeat (BUS_WIN) @(posedge bus_clk);
      #1;
      check((bcnt - b0) >= (e.on ? BUS_WIN : 0) && (e.on || bcnt == b0),
            {e.tag, "/R5"}, "bus pulses", bcnt - b0, e.on ? BUS_WIN : 0);
      @(negedge bus_clk);
      check(active == e.on, {e.tag, "/R9"}, "active flag", active, e.on);
      mon_busy = 1'b0;
    end
  end

  task automatic edge_walk(input bit opening, input string req);
    int prev;
    @(posedge ker_clk);
    #2;
    run_en = opening;
    for (int ed = 1; ed <= 3; ed++) begin
      prev = kcnt;
      @(posedge ker_clk);
      #1;
      if (opening)
        check((kcnt - prev) == (ed == 3 ? 1 : 0), req, $sformatf("edge %0d", ed),
              kcnt - prev, ed == 3 ? 1 : 0);
      else
        check((kcnt - prev) == (ed == 3 ? 0 : 1), req, $sformatf("edge %0d", ed),
              kcnt - prev, ed == 3 ? 0 : 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    run_en = 1'b1; slp_en = 1'b1; auto_en = 1'b1;
    cpu_state = 2'b00; dom_run = 1'b1; dom_pwr = 1'b1;
    repeat (6) @(posedge bus_clk);
    #1;
    // R8: all enables set but reset held
    check(kcnt == 0, "R8", "kernel pulses in reset", kcnt, 0);
    check(bcnt == 0, "R8", "bus pulses in reset", bcnt, 0);
    check(active == 1'b0, "R8", "active in reset", active, 0);
    @(negedge bus_clk);
    rst_n = 1'b1;

    // R1: run state
    drive(1, 0, 0, 2'b00, 0, 1, "R1");
    drive(0, 1, 1, 2'b00, 1, 1, "R1");
    drive(1, 1, 1, 2'b00, 0, 1, "R1");
    // R2: sleep state
    drive(1, 0, 1, 2'b01, 1, 1, "R2");
    drive(1, 1, 0, 2'b01, 0, 1, "R2");
    drive(0, 1, 1, 2'b01, 1, 1, "R2");
    // R3: stop state
    drive(1, 1, 0, 2'b10, 1, 1, "R3");
    drive(1, 0, 1, 2'b10, 1, 1, "R3");
    drive(1, 1, 1, 2'b10, 0, 1, "R3");
    drive(0, 1, 1, 2'b10, 1, 1, "R3");
    // R10: reserved state
    drive(1, 1, 1, 2'b11, 1, 1, "R10");
    // R4: domain unpowered
    drive(1, 1, 1, 2'b00, 1, 0, "R4");
    drive(1, 1, 1, 2'b10, 1, 0, "R4");

    // R6 / R7: latency at a known phase
    drive(0, 0, 0, 2'b00, 1, 1, "R1");
    edge_walk(1'b1, "R6");
    repeat (4) @(posedge ker_clk);
    edge_walk(1'b0, "R7");
    repeat (4) @(posedge bus_clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule